// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is a single inter-thread synchronisation cell that behaves as a counting semaphore with a 16-bit count. Requesters reach it through a read port and a write port. Each access carries a view code, and the view decides what the access does. The P (acquire) views read the count. If the count is nonzero they take one unit. The V (release) views give one unit back.

A blocking acquire on an empty count does not return data. It returns a blocked response and records the requester's ID in a waiting mask. The processor is expected to halt that requester. The next release puts the whole waiting mask on a wake output for a single cycle and then clears the mask. The woken requesters then retry.

There are two further views. The bypass view inspects the count directly. The control view holds three software-owned flag bits. The empty/full views belong to FIFO-type cells; on this cell they are inert. Address decoding and the halting of requesters stay outside the block.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0 and the control flags are 0. Control bit 17 is the FIFO-type indication and reads 0. No wake pulse is issued.
- R2: Every read gets exactly one response, one cycle after the request. A P read (view 4 = blocking, view 5 = non-blocking) returns the count as it stood before the decrement. If that count is nonzero, the count then drops by one.
- R3: A non-blocking P read (view 5) on a count of 0 returns 0. It is not flagged as blocked and leaves the count at 0.
- R4: A blocking P read (view 4) on a count of 0 returns data 0 with the blocked flag set. It sets bit `rd_id` of the waiting mask.
- R5: A V write (view 4 or 5) adds one to the count. At 0xFFFF the count stays at 0xFFFF. The write data has no effect.
- R6: A V write while the waiting mask is nonzero raises `wake_valid` for exactly one cycle on the next clock, with `wake_mask` equal to the mask. The mask is then empty. A V write with no waiters raises no wake.
- R7: A bypass read (view 0) returns the count as it stood before the operations of that cycle. A bypass write has no effect.
- R8: The empty/full views (2, 3) and the unused views (6, 7) read as 0. Writes to them change nothing.
- R9: When a P read and a V write arrive in the same cycle, the V is applied first. The P therefore sees the incremented count and cannot block.
- R10: A control write (view 1) stores data bits 16, 1 and 0. A control read returns them at the same positions, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request |
| rd_view | input | 3 | View code of the read |
| rd_id | input | 6 | Requester ID of the read |
| wr_valid | input | 1 | Write request |
| wr_view | input | 3 | View code of the write |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| rsp_blocked | output | 1 | Response is a blocked acquire |
| wake_valid | output | 1 | Wake pulse |
| wake_mask | output | 64 | Requesters to wake |

## Verification
The embedded assertions check several rules on every cycle:
- a response follows each read by one cycle;
- the count holds when no P or V access arrives;
- a release-only cycle never wraps the count at 0xFFFF;
- a wake is a single-cycle pulse, leaves the waiting mask empty and is never empty itself;
- a blocked response always leaves a recorded waiter.

Only the bench scenarios can show the values themselves:
- the pre-decrement data;
- the blocked flag at zero;
- the exact wake mask;
- the same-cycle ordering of a release and an acquire;
- that bypass writes, empty/full views and ignored write data leave the count untouched.

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int CNT_W = 16,
  parameter int NREQ  = 64,
  parameter int DW    = 32,
  localparam int IDW  = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_valid,
  input  logic [2:0]      rd_view,
  input  logic [IDW-1:0]  rd_id,
  input  logic            wr_valid,
  input  logic [2:0]      wr_view,
  input  logic [DW-1:0]   wr_data,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_blocked,
  output logic            wake_valid,
  output logic [NREQ-1:0] wake_mask
);
  localparam logic [2:0] VW_BYPASS = 3'd0;
  localparam logic [2:0] VW_CTRL   = 3'd1;
  localparam logic [2:0] VW_P_SYNC = 3'd4;
  localparam logic [2:0] VW_P_TRY  = 3'd5;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count, cnt_v, cnt_n;
  logic [NREQ-1:0]  waiting;
  logic             flg_t, flg_f, flg_e;
  logic [DW-1:0]    rd_mux;

  wire is_v    = wr_valid && (wr_view == VW_P_SYNC || wr_view == VW_P_TRY);
  wire is_p    = rd_valid && (rd_view == VW_P_SYNC || rd_view == VW_P_TRY);
  wire p_block = is_p && (rd_view == VW_P_SYNC) && (cnt_v == '0);
  wire ctrl_wr = wr_valid && (wr_view == VW_CTRL);

  assign cnt_v = (is_v && count != CMAX) ? count + 1'b1 : count;
  assign cnt_n = (is_p && cnt_v != '0) ? cnt_v - 1'b1 : cnt_v;

  always_comb begin
    rd_mux = '0;
    case (rd_view)
      VW_BYPASS: rd_mux = DW'(count);
      VW_CTRL: begin
        rd_mux[16] = flg_t;
        rd_mux[1]  = flg_f;
        rd_mux[0]  = flg_e;
      end
      VW_P_SYNC, VW_P_TRY: rd_mux = DW'(cnt_v);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      waiting     <= '0;
      {flg_t, flg_f, flg_e} <= 3'b000;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_blocked <= 1'b0;
      wake_valid  <= 1'b0;
      wake_mask   <= '0;
    end else begin
      count       <= cnt_n;
      rsp_valid   <= rd_valid;
      rsp_data    <= rd_valid ? rd_mux : '0;
      rsp_blocked <= p_block;
      wake_valid  <= is_v && (waiting != '0);
      wake_mask   <= is_v ? waiting : '0;
      if (is_v)         waiting <= '0;
      else if (p_block) waiting <= waiting | (NREQ'(1) << rd_id);
      if (ctrl_wr) {flg_t, flg_f, flg_e} <= {wr_data[16], wr_data[1], wr_data[0]};
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && is_v && !is_p) |=> count == CMAX);
  a_r8_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_v && !is_p) |=> $stable(count));
  a_r6_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |=> !wake_valid);
  a_r6_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (waiting == '0 && wake_mask != '0));
  a_r4_block_records: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> (waiting != '0 && rsp_data == '0));
endmodule

// File: tb/tb_sem_cell.sv
module tb_sem_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [2:0]  rd_view = '0;
  logic [5:0]  rd_id = '0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_view = '0;
  logic [31:0] wr_data = '0;
  logic        rsp_valid, rsp_blocked, wake_valid;
  logic [31:0] rsp_data;
  logic [63:0] wake_mask;

  always #5 clk = ~clk;

  sem_cell dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
    .wr_valid(wr_valid), .wr_view(wr_view), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_blocked(rsp_blocked),
    .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] q_data[$];
  logic        q_blk[$];
  string       q_tag[$];
  logic [63:0] w_mask[$];
  string       w_tag[$];

  logic [15:0] m_cnt = '0;
  logic [63:0] m_wait = '0;
  logic        m_t = 0, m_f = 0, m_e = 0;

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s: %s actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic op(bit re, logic [2:0] rv, logic [5:0] rid,
                    bit we, logic [2:0] wv, logic [31:0] wd, string tag);
    logic [15:0] cv;
    logic [31:0] ed;
    bit isv, isp, blk;
    @(negedge clk);
    rd_valid = re; rd_view = rv; rd_id = rid;
    wr_valid = we; wr_view = wv; wr_data = wd;
    isv = we && (wv == 3'd4 || wv == 3'd5);
    isp = re && (rv == 3'd4 || rv == 3'd5);
    cv  = (isv && m_cnt != 16'hFFFF) ? m_cnt + 16'd1 : m_cnt;
    blk = isp && rv == 3'd4 && cv == 0;
    if (re) begin
      case (rv)
        3'd0: ed = {16'h0, m_cnt};
        3'd1: ed = (32'(m_t) << 16) | (32'(m_f) << 1) | 32'(m_e);
        3'd4, 3'd5: ed = {16'h0, cv};
        default: ed = 32'h0;
      endcase
      q_data.push_back(ed); q_blk.push_back(blk); q_tag.push_back(tag);
    end
    m_cnt = (isp && cv != 0) ? cv - 16'd1 : cv;
    if (isv) begin
      if (m_wait != 0) begin w_mask.push_back(m_wait); w_tag.push_back(tag); end
      m_wait = '0;
    end else if (blk) m_wait |= (64'd1 << rid);
    if (we && wv == 3'd1) begin m_t = wd[16]; m_f = wd[1]; m_e = wd[0]; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_valid = 0; wr_valid = 0;
    end
  endtask

  task automatic rd(logic [2:0] v, logic [5:0] id, string tag); op(1, v, id, 0, 0, 0, tag); endtask
  task automatic wr(logic [2:0] v, logic [31:0] d, string tag); op(0, 0, 0, 1, v, d, tag); endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        checks++;
        if (q_data.size() == 0) fail("R2", "unexpected response", {32'h0, rsp_data}, 0);
        else begin
          logic [31:0] ed; logic eb; string t;
          ed = q_data.pop_front(); eb = q_blk.pop_front(); t = q_tag.pop_front();
          if (rsp_data !== ed) fail(t, "data", {32'h0, rsp_data}, {32'h0, ed});
          else if (rsp_blocked !== eb) fail(t, "blocked", {63'h0, rsp_blocked}, {63'h0, eb});
        end
      end
      if (wake_valid) begin
        checks++;
        if (w_mask.size() == 0) fail("R6", "unexpected wake", wake_mask, 0);
        else begin
          logic [63:0] em; string t;
          em = w_mask.pop_front(); t = w_tag.pop_front();
          if (wake_mask !== em) fail(t, "wake mask", wake_mask, em);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rsp_valid !== 0 || wake_valid !== 0) fail("R1", "outputs after reset", {62'h0, rsp_valid, wake_valid}, 0);
    rd(3'd0, 0, "R1 count");
    rd(3'd1, 0, "R1 control");
    wr(3'd4, 32'hDEAD_BEEF, "R5 data ignored");
    wr(3'd5, 32'h0, "R5");
    rd(3'd0, 0, "R7 bypass read");
    wr(3'd0, 32'h1234, "R7 bypass write");
    rd(3'd0, 0, "R7 after bypass write");
    rd(3'd5, 0, "R2 try");
    rd(3'd4, 0, "R2 sync");
    rd(3'd5, 0, "R3 try at zero");
    rd(3'd0, 0, "R3 count held");
    rd(3'd2, 0, "R8 ef sync");
    rd(3'd3, 0, "R8 ef try");
    rd(3'd7, 0, "R8 unused view");
    wr(3'd2, 32'h5, "R8 ef write");
    wr(3'd6, 32'h5, "R8 unused write");
    rd(3'd0, 0, "R8 count held");
    rd(3'd4, 6'd3, "R4 block id3");
    rd(3'd4, 6'd40, "R4 block id40");
    idle(2);
    wr(3'd4, 32'h0, "R6 wake");
    idle(3);
    wr(3'd5, 32'h0, "R6 no waiters");
    rd(3'd0, 0, "R6 count");
    op(1, 3'd4, 6'd1, 1, 3'd4, 32'h0, "R9 P with V");
    rd(3'd5, 0, "R9 drain");
    rd(3'd5, 0, "R9 drain");
    op(1, 3'd4, 6'd9, 1, 3'd5, 32'h0, "R9 no block at zero");
    rd(3'd0, 0, "R9 count");
    wr(3'd1, 32'h0003_0003, "R10 write");
    rd(3'd1, 0, "R10 read");
    for (int i = 0; i < 65535; i++) wr(3'd4, 32'h0, "R5 fill");
    wr(3'd5, 32'hFFFF_FFFF, "R5 saturate");
    rd(3'd0, 0, "R5 saturated");
    rd(3'd5, 0, "R2 at max");
    rd(3'd0, 0, "R2 after max");
    idle(4);
    checks++;
    if (q_data.size() != 0 || w_mask.size() != 0)
      fail("R2", "missing responses or wakes", q_data.size() + w_mask.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule